// File: doc/BRIEF.md
# Four-Lane Transceiver Power-Up Reset Sequencer

This block brings a four-lane serial transceiver out of reset in a controlled, timed order. The lanes are grouped in two pairs, and each pair shares one PLL. When a start pulse arrives while the block is idle, it first drives every lane reset, lane power-down and PLL reset to its active level, and it holds the PCS reset low. It then releases the controls one group at a time. For each pair the order is: the pair's power-downs, then that pair's PLL reset, then the pair's lane resets. The block waits a fixed settle time after the initial assertion and after every release step.

Once the last settle time has elapsed, the PCS reset is released. After a long gap, the block drives the PCS reset low again for a short pulse and then releases it for good. A one-cycle done pulse marks the end of the sequence. All delays are counted in clock cycles, derived from the `CLK_MHZ` parameter: settle time 15 µs, gap 1000 µs, pulse 20 µs. The pair count is a parameter and defaults to two. The analog transceiver and PLL lock detection lie outside this block.

Top module: `serdes_rst_seq`

## Requirements
- R1: While reset is held and after reset with no start, every lane reset, lane power-down and PLL reset output is 1 (active), `pcs_rst_n` is 0, and `busy` and `done` are 0.
- R2: A start sampled while `busy` is 0 makes all lane resets, power-downs and PLL resets 1, `pcs_rst_n` 0 and `busy` 1 from the next cycle, even when the previous sequence left them released.
- R3: The first release happens exactly S = 15·CLK_MHZ cycles after the cycle in which R2's state first appears.
- R4: Step k (k = 1..6) takes effect at S·k cycles after that cycle, in this order: 1 → lane_pdn[1:0] to 0, 2 → pll_rst[0] to 0, 3 → lane_rst[1:0] to 0, 4 → lane_pdn[3:2] to 0, 5 → pll_rst[1] to 0, 6 → lane_rst[3:2] to 0.
- R5: Between two release steps, and for S cycles after step 6, the outputs hold their values.
- R6: At 7·S cycles `pcs_rst_n` goes to 1. It goes to 0 after a further G = 1000·CLK_MHZ cycles, stays 0 for P = 20·CLK_MHZ cycles and then returns to 1. While `pcs_rst_n` is 1, all other control outputs are 0.
- R7: `done` is 1 for exactly one cycle, at 7·S+G+P cycles, which is the same cycle in which `pcs_rst_n` returns to 1. `busy` is 0 in that cycle, and `busy` never falls without `done`.
- R8: A start sampled while `busy` is 1 has no effect: the outputs follow R3 to R7 as if it had not arrived, and no released control is asserted again.
- R9: After completion, all lane and PLL controls stay 0, `pcs_rst_n` stays 1 and `busy` stays 0 until the next start.
- R10: Asserting `rst_n` in the middle of a sequence immediately returns every control to the R1 state, and the block is idle afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock of frequency CLK_MHZ MHz |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Sequence request, sampled on the rising edge |
| lane_rst | output | 2·PAIRS (4) | Lane resets, 1 = active |
| lane_pdn | output | 2·PAIRS (4) | Lane power-downs, 1 = powered down |
| pll_rst | output | PAIRS (2) | PLL resets, bit p serves lanes 2p and 2p+1, 1 = active |
| pcs_rst_n | output | 1 | PCS reset, 0 = active |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with CLK_MHZ = 1, which gives a settle time of 15 cycles, a gap of 1000 cycles and a pulse of 20 cycles. A full sequence therefore takes 1125 cycles, so every cycle of several complete runs can be compared against an arithmetic timeline. Those runs cover a start from the freshly reset state and a restart from the completed state. Stray start pulses are injected at a fixed stride through a whole run, and a reset is applied in the middle of a run. As a result, each release edge, each settle window, both PCS edges and the done cycle are all checked at the exact cycle.

// File: rtl/srs_pkg.sv
package srs_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_HOLD = 3'd1,
    PH_STEP = 3'd2,
    PH_GAP  = 3'd3,
    PH_LOW  = 3'd4
  } phase_e;

  // Microseconds to whole clock cycles for an integer MHz clock.
  function automatic int unsigned us_to_cycles(input int unsigned mhz,
                                               input int unsigned us);
    return mhz * us;
  endfunction

endpackage

// File: rtl/srs_rst_sync.sv
module srs_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign srst_n = sync_q;

endmodule

// File: rtl/srs_timer.sv
module srs_timer #(
  parameter int unsigned TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load) begin
      cnt_en = 1'b1;
      cnt_d  = load_val;
    end else if (cnt_q != '0) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/srs_ctrl.sv
module srs_ctrl
  import srs_pkg::*;
#(
  parameter int unsigned PAIRS    = 2,
  parameter int unsigned STEP_CYC = 15,
  parameter int unsigned GAP_CYC  = 1000,
  parameter int unsigned LOW_CYC  = 20,
  parameter int unsigned TW       = 10,
  parameter int unsigned SW       = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          expired,
  output logic          load,
  output logic [TW-1:0] load_val,
  output phase_e        phase,
  output logic [SW-1:0] step,
  output logic          done
);

  localparam int unsigned LAST_STEP = 3 * PAIRS;
  localparam int unsigned END_STEP  = LAST_STEP + 1;
  localparam logic [TW-1:0] STEP_V  = TW'(STEP_CYC - 1);
  localparam logic [TW-1:0] GAP_V   = TW'(GAP_CYC - 1);
  localparam logic [TW-1:0] LOW_V   = TW'(LOW_CYC - 1);

  phase_e        phase_q, phase_d;
  logic [SW-1:0] step_q, step_d;
  logic          done_q, done_d;
  logic          state_en;

  always_comb begin
    phase_d  = phase_q;
    step_d   = step_q;
    done_d   = 1'b0;
    load     = 1'b0;
    load_val = '0;
    unique case (phase_q)
      PH_IDLE: begin
        if (start) begin
          phase_d  = PH_HOLD;
          step_d   = '0;
          load     = 1'b1;
          load_val = STEP_V;
        end
      end
      PH_HOLD: begin
        if (expired) begin
          phase_d  = PH_STEP;
          step_d   = SW'(1);
          load     = 1'b1;
          load_val = STEP_V;
        end
      end
      PH_STEP: begin
        if (expired) begin
          load = 1'b1;
          if (step_q == SW'(LAST_STEP)) begin
            phase_d  = PH_GAP;
            load_val = GAP_V;
          end else begin
            step_d   = step_q + 1'b1;
            load_val = STEP_V;
          end
        end
      end
      PH_GAP: begin
        if (expired) begin
          phase_d  = PH_LOW;
          load     = 1'b1;
          load_val = LOW_V;
        end
      end
      PH_LOW: begin
        if (expired) begin
          phase_d = PH_IDLE;
          step_d  = SW'(END_STEP);
          done_d  = 1'b1;
        end
      end
      default: begin
        phase_d = PH_IDLE;
        step_d  = '0;
      end
    endcase
  end

  assign state_en = (phase_d != phase_q) || (step_d != step_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      step_q  <= '0;
    end else if (state_en) begin
      phase_q <= phase_d;
      step_q  <= step_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else begin
      done_q <= done_d;
    end
  end

  assign phase = phase_q;
  assign step  = step_q;
  assign done  = done_q;

endmodule

// File: rtl/srs_decode.sv
module srs_decode
  import srs_pkg::*;
#(
  parameter int unsigned PAIRS = 2,
  parameter int unsigned SW    = 3
) (
  input  phase_e             phase,
  input  logic [SW-1:0]      step,
  output logic [2*PAIRS-1:0] lane_rst,
  output logic [2*PAIRS-1:0] lane_pdn,
  output logic [PAIRS-1:0]   pll_rst,
  output logic               pcs_rst_n,
  output logic               busy
);

  localparam int unsigned END_STEP = 3 * PAIRS + 1;

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    localparam int unsigned PDN_AT = 3 * p + 1;
    localparam int unsigned PLL_AT = 3 * p + 2;
    localparam int unsigned RST_AT = 3 * p + 3;
    assign lane_pdn[2*p +: 2] = {2{step < SW'(PDN_AT)}};
    assign pll_rst[p]         = (step < SW'(PLL_AT));
    assign lane_rst[2*p +: 2] = {2{step < SW'(RST_AT)}};
  end

  assign pcs_rst_n = (phase == PH_GAP) ||
                     ((phase == PH_IDLE) && (step == SW'(END_STEP)));
  assign busy      = (phase != PH_IDLE);

endmodule

// File: rtl/serdes_rst_seq.sv
module serdes_rst_seq
  import srs_pkg::*;
#(
  parameter int unsigned CLK_MHZ = 250,
  parameter int unsigned PAIRS   = 2,
  parameter int unsigned STEP_US = 15,
  parameter int unsigned GAP_US  = 1000,
  parameter int unsigned LOW_US  = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  output logic [2*PAIRS-1:0] lane_rst,
  output logic [2*PAIRS-1:0] lane_pdn,
  output logic [PAIRS-1:0]   pll_rst,
  output logic               pcs_rst_n,
  output logic               busy,
  output logic               done
);

  localparam int unsigned STEP_CYC = us_to_cycles(CLK_MHZ, STEP_US);
  localparam int unsigned GAP_CYC  = us_to_cycles(CLK_MHZ, GAP_US);
  localparam int unsigned LOW_CYC  = us_to_cycles(CLK_MHZ, LOW_US);
  localparam int unsigned MAX_CYC  = (GAP_CYC > STEP_CYC) ?
                                     ((GAP_CYC > LOW_CYC) ? GAP_CYC : LOW_CYC) :
                                     ((STEP_CYC > LOW_CYC) ? STEP_CYC : LOW_CYC);
  localparam int unsigned TW       = $clog2(MAX_CYC + 1);
  localparam int unsigned SW       = $clog2(3 * PAIRS + 2);

  logic          srst_n;
  logic          tmr_load;
  logic [TW-1:0] tmr_val;
  logic          tmr_expired;
  phase_e        phase;
  logic [SW-1:0] step;

  srs_rst_sync u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  srs_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst_n    (srst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  srs_ctrl #(
    .PAIRS    (PAIRS),
    .STEP_CYC (STEP_CYC),
    .GAP_CYC  (GAP_CYC),
    .LOW_CYC  (LOW_CYC),
    .TW       (TW),
    .SW       (SW)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (srst_n),
    .start    (start),
    .expired  (tmr_expired),
    .load     (tmr_load),
    .load_val (tmr_val),
    .phase    (phase),
    .step     (step),
    .done     (done)
  );

  srs_decode #(.PAIRS(PAIRS), .SW(SW)) u_decode (
    .phase     (phase),
    .step      (step),
    .lane_rst  (lane_rst),
    .lane_pdn  (lane_pdn),
    .pll_rst   (pll_rst),
    .pcs_rst_n (pcs_rst_n),
    .busy      (busy)
  );

endmodule

// File: rtl/srs_checker.sv
module srs_checker #(
  parameter int unsigned PAIRS = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic [2*PAIRS-1:0] lane_rst,
  input logic [2*PAIRS-1:0] lane_pdn,
  input logic [PAIRS-1:0]   pll_rst,
  input logic               pcs_rst_n,
  input logic               busy,
  input logic               done
);

  assert_start_arms_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy && (&lane_rst) && (&lane_pdn) && (&pll_rst) && !pcs_rst_n);

  for (genvar p = 0; p < PAIRS; p++) begin : g_order
    assert_pll_after_pdn_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !pll_rst[p] |-> (lane_pdn[2*p +: 2] == 2'b00));
    assert_lane_after_pll_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_rst[2*p +: 2] != 2'b11) |-> !pll_rst[p]);
    if (p > 0) begin : g_prev
      assert_pair_after_prev_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_pdn[2*p +: 2] != 2'b11) |-> (lane_rst[2*p-2 +: 2] == 2'b00));
    end
  end

  assert_pcs_after_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pcs_rst_n |-> (lane_rst == '0) && (lane_pdn == '0) && (pll_rst == '0));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_busy_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_no_reassert_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !pll_rst[0] |=> !pll_rst[0]);

endmodule

bind serdes_rst_seq srs_checker #(.PAIRS(PAIRS)) u_srs_checker (
  .clk       (clk),
  .rst_n     (srst_n),
  .start     (start),
  .lane_rst  (lane_rst),
  .lane_pdn  (lane_pdn),
  .pll_rst   (pll_rst),
  .pcs_rst_n (pcs_rst_n),
  .busy      (busy),
  .done      (done)
);

// File: tb/serdes_rst_seq_tb_top.sv
module serdes_rst_seq_tb_top;

  localparam int MHZ = 1;
  localparam int N   = 15 * MHZ;
  localparam int G   = 1000 * MHZ;
  localparam int L   = 20 * MHZ;
  localparam int T   = 7 * N + G + L;

  logic       clk;
  logic       rst_n;
  logic       start;
  logic [3:0] lane_rst;
  logic [3:0] lane_pdn;
  logic [1:0] pll_rst;
  logic       pcs_rst_n;
  logic       busy;
  logic       done;

  int checks = 0;
  int errors = 0;
  int t = 0;
  bit running = 0;
  bit arm = 0;
  bit ign_flag = 0;
  bit finished = 0;

  serdes_rst_seq #(.CLK_MHZ(MHZ), .PAIRS(2)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .lane_rst  (lane_rst),
    .lane_pdn  (lane_pdn),
    .pll_rst   (pll_rst),
    .pcs_rst_n (pcs_rst_n),
    .busy      (busy),
    .done      (done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  localparam logic [12:0] FRESH = {4'hF, 4'hF, 2'b11, 1'b0, 1'b0, 1'b0};

  function automatic logic [12:0] expect_at(input int tt);
    int k;
    logic [3:0] lr, lp;
    logic [1:0] pl;
    logic pcs;
    k = (tt >= 7 * N) ? 7 : tt / N;
    for (int p = 0; p < 2; p++) begin
      lp[2*p +: 2] = (k >= 3 * p + 1) ? 2'b00 : 2'b11;
      pl[p]        = !(k >= 3 * p + 2);
      lr[2*p +: 2] = (k >= 3 * p + 3) ? 2'b00 : 2'b11;
    end
    pcs = (tt >= 7 * N) && !((tt >= 7 * N + G) && (tt < T));
    return {lr, lp, pl, pcs, (tt < T), (tt == T)};
  endfunction

  task automatic check_now(input string over);
    logic [12:0] got, exp;
    string req;
    got = {lane_rst, lane_pdn, pll_rst, pcs_rst_n, busy, done};
    exp = running ? expect_at(t) : FRESH;
    if (over != "")           req = over;
    else if (!running)        req = "R1";
    else if (t == 0)          req = "R2";
    else if (t < N)           req = "R3";
    else if (t < 7 * N)       req = ((t % N) == 0) ? "R4" : "R5";
    else if (t < T)           req = "R6";
    else if (t == T)          req = "R7";
    else                      req = "R9";
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s t=%0d: got rst=%b pdn=%b pll=%b pcs_n=%b busy=%b done=%b, expected rst=%b pdn=%b pll=%b pcs_n=%b busy=%b done=%b",
               req, t, got[12:9], got[8:5], got[4:3], got[2], got[1], got[0],
               exp[12:9], exp[8:5], exp[4:3], exp[2], exp[1], exp[0]);
    end
  endtask

  // mode 0: no start, 1: start request, 2: stray start only while busy
  task automatic tick(input int mode, input string over);
    string tag;
    @(negedge clk);
    if (arm) begin
      t = 0;
      arm = 0;
      running = 1;
    end else if (running) begin
      t++;
    end
    tag = ign_flag ? "R8" : over;
    ign_flag = 0;
    check_now(tag);
    start = 1'b0;
    if (mode == 1) begin
      start = 1'b1;
      if (!running || t >= T) arm = 1;
    end else if (mode == 2 && running && t < T) begin
      start = 1'b1;
      ign_flag = 1;
    end
  endtask

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    repeat (3) @(negedge clk);
    check_now("R1");
    rst_n = 1'b1;
    repeat (6) tick(0, "R1");

    // First run from fresh reset, stray starts every 97 cycles (R8)
    tick(1, "R1");
    for (int i = 0; i < T + 12; i++) tick(((i % 97) == 50) ? 2 : 0, "");

    // Restart from completed state (R2, R9)
    tick(1, "R9");
    for (int i = 0; i < 100; i++) tick(((i % 61) == 30) ? 2 : 0, "");

    // Reset in the middle of a sequence (R10)
    @(negedge clk);
    rst_n = 1'b0;
    running = 0;
    arm = 0;
    ign_flag = 0;
    #1;
    check_now("R10");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) tick(0, "R10");

    // Third clean run
    tick(1, "R10");
    for (int i = 0; i < T + 4; i++) tick(0, "");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got no completion, expected end of test");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule